// File: doc/BRIEF.md
# Reduction Set Completion Tracker

This block sits beside a pipelined floating-point reduction and keeps, for every reduction set, a running count of the partial values that are still alive. These values can sit in buffers, in the adder pipeline or at the adder's output. The reducer reports three kinds of event, and each can arrive in any cycle together with the others. A fresh value of a set enters. An addition of two values of a set is launched, and two values become one. A result of a set leaves the adder. When a result leaves the adder and it is the only live value of its set, the set is finished. The tracker then pulses its set ID so the reducer can release the value downstream.

Each event source owns a separate counter table that is indexed by set ID. No two sources ever write the same table, so all three events can be absorbed in one cycle. A table's entry is read one cycle and written back the next, with a bypass for back-to-back updates. The live count of a set is the modular sum of its three table entries. The counts are signed and 8 bits wide by default, and finished sets return to a sum of zero so the same ID can be reused at once.

Top module: `setdone_tracker`

## Requirements
- R1: After reset every set has a live count of zero and `fin_vld` is low, so a set whose first value is followed by its result reports completion.
- R2: Each cycle with `val_vld` high adds one to the live count of set `val_set`.
- R3: Each cycle with `op_vld` high subtracts one from the live count of set `op_set`.
- R4: When `res_vld` is high in cycle t and the live count of `res_set` equals exactly one, then in cycle t+1 `fin_vld` is high and `fin_set` equals that `res_set`.
- R5: When `res_vld` is high and the live count of `res_set` is not one, `fin_vld` stays low in cycle t+1 and the count of that set is unchanged.
- R6: Value and addition events in the same cycle as a result event for the same set are included in the count that the completion decision uses.
- R7: A completion brings the set's live count back to zero, so a further result of that set with no new values does not complete it.
- R8: Events to the same set in consecutive cycles, including a completion followed at once by new events, are all counted with no lost update.
- R9: Counts of different sets are independent; events on one set never change the completion of another.
- R10: `fin_vld` is never high in a cycle that does not follow a cycle with `res_vld` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| val_vld | input | 1 | A new value of a set enters the reduction |
| val_set | input | SET_W | Set ID of the new value |
| op_vld | input | 1 | An addition of two values of one set is launched |
| op_set | input | SET_W | Set ID of the launched addition |
| res_vld | input | 1 | A result leaves the adder |
| res_set | input | SET_W | Set ID of the adder result |
| fin_vld | output | 1 | One-cycle pulse: the set has been reduced to one value |
| fin_set | output | SET_W | Set ID of the finished set |

## Verification
A value arrival, an addition launch and a completion decision can all fall in the same cycle on one set ID. A completion can also be followed at once by new events to that ID, so the table write-back and a fresh read meet on one entry. The bench provokes both collisions with directed sequences. Its random traffic is drawn from a small pool of set IDs so that these collisions recur often. Each completion pulse, or its absence, is judged one cycle after the result event against a per-set integer count in the bench. That count applies arrivals and launches before it decides on the result.

// File: rtl/setdone_tracker.sv
module setdone_tracker #(
  parameter int SET_W = 6,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             val_vld,
  input  logic [SET_W-1:0] val_set,
  input  logic             op_vld,
  input  logic [SET_W-1:0] op_set,
  input  logic             res_vld,
  input  logic [SET_W-1:0] res_set,
  output logic             fin_vld,
  output logic [SET_W-1:0] fin_set
);
  localparam int SETS  = 1 << SET_W;
  localparam int BANKS = 3;

  logic [BANKS-1:0]            ev_vld;
  logic [BANKS-1:0][SET_W-1:0] ev_set;
  logic [BANKS-1:0]            st_vld;
  logic [BANKS-1:0][SET_W-1:0] st_set;
  logic [BANKS-1:0][CNT_W-1:0] own_w, chk_w, wr_dat;
  logic [BANKS-1:0]            wr_en;
  logic [CNT_W-1:0]            total;
  logic                        corr_val, corr_op;

  assign ev_vld = {res_vld, op_vld, val_vld};
  assign ev_set = {res_set, op_set, val_set};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_vld <= '0;
      st_set <= '0;
    end else begin
      st_vld <= ev_vld;
      st_set <= ev_set;
    end
  end

  assign corr_val = st_vld[0] && (st_set[0] == st_set[2]);
  assign corr_op  = st_vld[1] && (st_set[1] == st_set[2]);
  assign total    = chk_w[0] + chk_w[1] + chk_w[2]
                  + CNT_W'(corr_val) - CNT_W'(corr_op);
  assign fin_vld  = st_vld[2] && (total == CNT_W'(1));
  assign fin_set  = st_set[2];

  for (genvar k = 0; k < BANKS; k++) begin : bank
    logic signed [CNT_W-1:0] tab [SETS];
    logic        [CNT_W-1:0] own_q, chk_q;

    if (k == 0) begin : g_inc
      assign wr_en[k]  = st_vld[k];
      assign wr_dat[k] = own_q + CNT_W'(1);
    end else if (k == 1) begin : g_dec
      assign wr_en[k]  = st_vld[k];
      assign wr_dat[k] = own_q - CNT_W'(1);
    end else begin : g_rel
      assign wr_en[k]  = fin_vld;
      assign wr_dat[k] = own_q - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < SETS; i++) tab[i] <= '0;
        own_q <= '0;
        chk_q <= '0;
      end else begin
        if (wr_en[k]) tab[st_set[k]] <= wr_dat[k];
        own_q <= (wr_en[k] && st_set[k] == ev_set[k]) ? wr_dat[k] : tab[ev_set[k]];
        chk_q <= (wr_en[k] && st_set[k] == res_set)   ? wr_dat[k] : tab[res_set];
      end
    end

    assign own_w[k] = own_q;
    assign chk_w[k] = chk_q;
  end

  function automatic logic [CNT_W-1:0] msum(input logic [SET_W-1:0] s);
    return bank[0].tab[s] + bank[1].tab[s] + bank[2].tab[s];
  endfunction

  logic [CNT_W-1:0] sum_val_now, sum_op_now;
  assign sum_val_now = msum(st_set[0]);
  assign sum_op_now  = msum(st_set[1]);

  assert_incoming_adds_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_vld == 3'b001) |=> (msum($past(st_set[0])) - $past(sum_val_now)) == CNT_W'(1));

  assert_launch_removes_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_vld == 3'b010) |=> ($past(sum_op_now) - msum($past(st_set[1]))) == CNT_W'(1));

  assert_fin_follows_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fin_vld |-> $past(res_vld) && fin_set == $past(res_set));

  assert_no_release_keeps_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_vld[2] && !fin_vld) |=> msum($past(st_set[2])) == $past(total));

  assert_release_zeroes_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fin_vld |=> msum($past(fin_set)) == '0);

  assert_fin_needs_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld |=> !fin_vld);

  logic unused_own;
  assign unused_own = ^own_w;
endmodule

// File: tb/test_setdone_tracker.sv
module test_setdone_tracker;
  logic clk = 0, rst_n = 0;
  logic val_vld = 0, op_vld = 0, res_vld = 0;
  logic [5:0] val_set = 0, op_set = 0, res_set = 0;
  logic fin_vld;
  logic [5:0] fin_set;

  setdone_tracker i_setdone_tracker (
    .clk(clk), .rst_n(rst_n),
    .val_vld(val_vld), .val_set(val_set),
    .op_vld(op_vld), .op_set(op_set),
    .res_vld(res_vld), .res_set(res_set),
    .fin_vld(fin_vld), .fin_set(fin_set));

  always #5 clk = ~clk;

  int checks = 0, failures = 0;
  int cnt [64];
  bit exp_vld = 0;
  logic [5:0] exp_set = 0;
  string exp_tag = "R1";
  bit finished = 0;

  function automatic bit predict(bit iv, logic [5:0] is, bit ov, logic [5:0] os,
                                 bit rv, logic [5:0] rs);
    if (iv) cnt[is] = cnt[is] + 1;
    if (ov) cnt[os] = cnt[os] - 1;
    if (rv && cnt[rs] == 1) begin
      cnt[rs] = 0;
      return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic check_pending();
    checks++;
    if (fin_vld !== exp_vld || (exp_vld && fin_set !== exp_set)) begin
      failures++;
      $display("FAIL %s fin_vld=%0d fin_set=%0d expected fin_vld=%0d fin_set=%0d",
               exp_tag, fin_vld, fin_set, exp_vld, exp_set);
    end
  endtask

  task automatic step(bit iv, logic [5:0] is, bit ov, logic [5:0] os,
                      bit rv, logic [5:0] rs, string tag);
    @(negedge clk);
    check_pending();
    exp_vld = predict(iv, is, ov, os, rv, rs);
    exp_set = rs;
    exp_tag = tag;
    val_vld = iv; val_set = is;
    op_vld = ov;  op_set = os;
    res_vld = rv; res_set = rs;
  endtask

  task automatic idle(string tag);
    step(0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) cnt[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    idle("R1");
    // R1 / R4: lone value of a set, then its result
    step(1, 5, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 1, 5, "R4");
    // R7: another result of the released set does not complete it
    step(0, 0, 0, 0, 1, 5, "R7");
    idle("R7");
    // R6: value arrives in the same cycle as the result
    step(1, 9, 0, 0, 1, 9, "R6");
    step(1, 9, 0, 0, 0, 0, "R6");
    step(1, 9, 0, 0, 0, 0, "R6");
    step(0, 0, 1, 9, 1, 9, "R6");
    idle("R6");
    // R5 / R3: two live values, no completion until a launch merges them
    step(1, 3, 0, 0, 0, 0, "R5");
    step(1, 3, 0, 0, 0, 0, "R5");
    step(0, 0, 0, 0, 1, 3, "R5");
    step(0, 0, 0, 0, 1, 3, "R5");
    step(0, 0, 1, 3, 0, 0, "R3");
    step(0, 0, 0, 0, 1, 3, "R3");
    idle("R3");
    // R2: three values, two launches
    step(1, 4, 0, 0, 0, 0, "R2");
    step(1, 4, 0, 0, 0, 0, "R2");
    step(1, 4, 1, 4, 0, 0, "R2");
    step(0, 0, 1, 4, 1, 4, "R2");
    idle("R2");
    // R8: back-to-back events on one set, completion then reuse at once
    step(1, 7, 0, 0, 0, 0, "R8");
    step(1, 7, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 1, 7, "R8");
    step(0, 0, 1, 7, 0, 0, "R8");
    step(0, 0, 0, 0, 1, 7, "R8");
    step(1, 8, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 1, 8, "R8");
    step(1, 8, 0, 0, 1, 8, "R8");
    step(0, 0, 0, 0, 1, 8, "R8");
    idle("R8");
    // R9: two sets in parallel
    step(1, 1, 0, 0, 0, 0, "R9");
    step(1, 2, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 1, 1, "R9");
    step(0, 0, 0, 0, 1, 2, "R9");
    idle("R9");
    // random traffic over a small pool of set IDs
    void'($urandom(32'd1357));
    for (int n = 0; n < 4000; n++) begin
      bit iv, ov, rv;
      logic [5:0] is, os, rs;
      int avail;
      is = ($urandom % 8 == 0) ? 6'($urandom % 64) : 6'($urandom % 4);
      os = 6'($urandom % 4);
      rs = ($urandom % 8 == 0) ? 6'($urandom % 64) : 6'($urandom % 4);
      iv = ($urandom % 10 < 6) && cnt[is] < 20;
      avail = cnt[os] + ((iv && is == os) ? 1 : 0);
      ov = ($urandom % 10 < 4) && avail >= 2;
      rv = ($urandom % 2) == 1;
      step(iv, is, ov, os, rv, rs, "R4");
    end
    idle("R5");
    idle("R10");
    @(negedge clk);
    check_pending();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule